// File: doc/BRIEF.md
# Prescaled PWM Channel Generator

This block produces one pulse-width-modulated output. A small register write port sets the reference tick source, a two-stage prescaler (a non-power-of-two predivider followed by a power-of-two divider), the period length (64 or 512 counts) and a 9-bit duty value. The tick inputs are single-cycle enable strobes in the block's clock domain, one per reference rate (nominally 1024 Hz, 32768 Hz and 19.2 MHz).

The duty value comes either from a software register or from an external ramp-pattern input. Software duty writes are held in staging and become live only when a sync command is written. When glitch-free mode is on, a new duty value is applied only at the period boundary. Otherwise it is applied on the next clock. A one-cycle period-end pulse is exported so that an outside pattern sequencer can step in time with the PWM periods.

Top module: `prescaled_pwm_gen`

## Requirements
- R1: Bit 2 of register 0 selects the period length: 0 gives 64 counts (6-bit counter) and 1 gives 512 counts (9-bit counter).
- R2: Bits [1:0] of register 0 select `ref_tick[0]`, `[1]` or `[2]` as the count source for values 0, 1 and 2. Value 3 selects no source, and the period counter then stands still.
- R3: Bits [1:0] of register 1 set the predivide ratio: code 0 gives 1, code 1 gives 3, code 2 gives 5 and code 3 gives 6 selected ticks per prescaled tick.
- R4: Bits [4:2] of register 1 hold an exponent e in the range 0 to 7. One counter step occurs for every 2^e prescaled ticks.
- R5: The software duty value is 9 bits wide. Its low 8 bits are written at register 2, and bit 8 is written as bit 0 of register 3.
- R6: Staged software duty becomes the committed duty only on a write to register 5 with bit 0 set. This command is a strobe that acts once per write, and nothing else changes the committed duty.
- R7: Bit 0 of register 4 enables glitch-free update. When it is 1, the active duty takes a new value only at a period end. When it is 0, the active duty follows the selected source one clock later.
- R8: Bit 1 of register 4 selects the duty source: 0 selects the `pat_duty` input and 1 selects the committed software duty.
- R9: `pwm_out` can be high only while bit 7 of register 4 is 1. When that bit is 0, the output stays low and the period counter keeps running.
- R10: `pwm_out` is high while the counter is below the active duty. A duty of 0 gives a constant low output. A duty at or above the period length gives a constant high output.
- R11: `period_end` is a one-clock pulse in the last clock of each period. For reference divide D, predivide ratio P, exponent e and period length N, consecutive pulses are D*P*2^e*N clocks apart.
- R12: After reset all configuration fields are 0: tick source 0, 64-count period, ratio 1, exponent 0, duty 0, pattern source, glitch-free off and output disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 3 | Reference tick strobes, one per selectable rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 8 | Register write data |
| pat_duty | input | 9 | Duty value from an external ramp-pattern source |
| pwm_out | output | 1 | PWM output |
| period_end | output | 1 | One-clock pulse in the last clock of each period |

## Verification
The hardest case to reach from the ports is the difference between immediate and glitch-free update, because it shows only when the duty changes partway through a period. The stimulus runs with a tick on every clock and a predivide and exponent of 1, so the counter value equals the number of clocks since the last period-end pulse. The bench then changes the pattern input at a known count. The number of high clocks in that period then identifies which update rule was applied: 35 for immediate update and 5 for the glitch-free case. The sync gating is tested in a similar way: a staged duty write is made with no sync, and the bench confirms the measured high time does not change until the sync command is written.

// File: rtl/ppwm_pkg.sv
// Shared constants, register layout and configuration type for the
// prescaled PWM channel. Assumes one clock domain for every user.
package ppwm_pkg;

    localparam int DUTY_W    = 9;
    localparam int SHORT_W   = 6;
    localparam int EXP_W     = 3;
    localparam int PSEL_W    = 2;
    localparam int TSEL_W    = 2;
    localparam int NUM_TICKS = 3;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int PRE_CNT_W = 3;

    // Field positions inside the write data byte
    localparam int BIT_WIDE   = 2;
    localparam int BIT_OUTEN  = 7;
    localparam int BIT_SRCSW  = 1;
    localparam int BIT_GLITCH = 0;
    localparam int BIT_SYNC   = 0;
    localparam int EXP_LSB    = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CLK  = 3'd0,
        A_DIV  = 3'd1,
        A_DLO  = 3'd2,
        A_DHI  = 3'd3,
        A_CTRL = 3'd4,
        A_SYNC = 3'd5
    } ppwm_addr_e;

    typedef struct packed {
        logic [TSEL_W-1:0] tick_sel;
        logic              wide;
        logic [PSEL_W-1:0] pre_sel;
        logic [EXP_W-1:0]  exp_sel;
        logic              glitch_free;
        logic              src_sw;
        logic              out_en;
    } ppwm_cfg_t;

    // Terminal count of the predivider (ratio minus one) per code
    function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PSEL_W-1:0] code);
        case (code)
            2'd0:    pre_limit = 3'd0;
            2'd1:    pre_limit = 3'd2;
            2'd2:    pre_limit = 3'd4;
            default: pre_limit = 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/ppwm_regs.sv
// Configuration register file with staged and committed software duty.
// Assumes writes are single-cycle strobes; there is no read path.
module ppwm_regs
    import ppwm_pkg::*;
#(
    parameter int P_DUTY_W = DUTY_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_DATA_W-1:0] wr_data,
    output ppwm_cfg_t           cfg,
    output logic [P_DUTY_W-1:0] sw_duty
);
    localparam int HI_W = P_DUTY_W - P_DATA_W;

    logic [P_DUTY_W-1:0] staged_q;
    logic                sync_cmd;

    assign sync_cmd = wr_en && (wr_addr == A_SYNC) && wr_data[BIT_SYNC];

    // Capture configuration fields and staged duty on register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            staged_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CLK: begin
                    cfg.tick_sel <= wr_data[TSEL_W-1:0];
                    cfg.wide     <= wr_data[BIT_WIDE];
                end
                A_DIV: begin
                    cfg.pre_sel <= wr_data[PSEL_W-1:0];
                    cfg.exp_sel <= wr_data[EXP_LSB +: EXP_W];
                end
                A_DLO:   staged_q[P_DATA_W-1:0] <= wr_data;
                A_DHI:   staged_q[P_DUTY_W-1:P_DATA_W] <= wr_data[HI_W-1:0];
                A_CTRL: begin
                    cfg.out_en      <= wr_data[BIT_OUTEN];
                    cfg.src_sw      <= wr_data[BIT_SRCSW];
                    cfg.glitch_free <= wr_data[BIT_GLITCH];
                end
                default: ;
            endcase
        end
    end

    // Commit the staged duty only when a sync command arrives
    always_ff @(posedge clk) begin
        if (!rst_n)
            sw_duty <= '0;
        else if (sync_cmd)
            sw_duty <= staged_q;
    end

endmodule

// File: rtl/ppwm_prescaler.sv
// Reference tick selection, fixed-ratio predivider and 2^e divider.
// Produces a one-clock step strobe. Counters wrap with >= so that a
// smaller ratio written mid-count cannot strand them above the limit.
module ppwm_prescaler
    import ppwm_pkg::*;
#(
    parameter int P_TICKS  = NUM_TICKS,
    parameter int P_TSEL_W = TSEL_W,
    parameter int P_PSEL_W = PSEL_W,
    parameter int P_EXP_W  = EXP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_TICKS-1:0]  ref_tick,
    input  logic [P_TSEL_W-1:0] tick_sel,
    input  logic [P_PSEL_W-1:0] pre_sel,
    input  logic [P_EXP_W-1:0]  exp_sel,
    output logic                step
);
    localparam int XCNT_W = (1 << P_EXP_W) - 1;

    logic                 sel_tick;
    logic [PRE_CNT_W-1:0] pre_cnt;
    logic [PRE_CNT_W-1:0] pre_lim;
    logic                 pre_pulse;
    logic [XCNT_W-1:0]    x_cnt;
    logic [XCNT_W-1:0]    x_lim;

    // Pick the chosen reference tick; unused codes give no tick
    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < P_TICKS; i++)
            if (tick_sel == P_TSEL_W'(i))
                sel_tick = ref_tick[i];
    end

    assign pre_lim   = pre_limit(pre_sel);
    assign pre_pulse = sel_tick && (pre_cnt >= pre_lim);
    assign x_lim     = ~({XCNT_W{1'b1}} << exp_sel);
    assign step      = pre_pulse && (x_cnt >= x_lim);

    // Predivider: count selected ticks up to the ratio
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_cnt <= '0;
        else if (sel_tick)
            pre_cnt <= pre_pulse ? '0 : pre_cnt + 1'b1;
    end

    // Exponent divider: count predivided ticks up to 2^e
    always_ff @(posedge clk) begin
        if (!rst_n)
            x_cnt <= '0;
        else if (pre_pulse)
            x_cnt <= step ? '0 : x_cnt + 1'b1;
    end

endmodule

// File: rtl/ppwm_counter.sv
// Period counter, active-duty holder and output comparator.
// Assumes req_duty is stable for the clock in which it is captured.
module ppwm_counter
    import ppwm_pkg::*;
#(
    parameter int P_DUTY_W  = DUTY_W,
    parameter int P_SHORT_W = SHORT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                wide,
    input  logic                glitch_free,
    input  logic                out_en,
    input  logic [P_DUTY_W-1:0] req_duty,
    output logic [P_DUTY_W-1:0] cnt,
    output logic [P_DUTY_W-1:0] active_duty,
    output logic                period_end,
    output logic                pwm_out
);
    localparam logic [P_DUTY_W-1:0] MAX_LONG  = P_DUTY_W'((1 << P_DUTY_W) - 1);
    localparam logic [P_DUTY_W-1:0] MAX_SHORT = P_DUTY_W'((1 << P_SHORT_W) - 1);

    logic [P_DUTY_W-1:0] cnt_max;

    assign cnt_max    = wide ? MAX_LONG : MAX_SHORT;
    assign period_end = step && (cnt >= cnt_max);
    assign pwm_out    = out_en && (cnt < active_duty);

    // Advance the period counter once per prescaled step
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= period_end ? '0 : cnt + 1'b1;
    end

    // Load the duty immediately, or only at a period end when glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_duty <= '0;
        else if (!glitch_free || period_end)
            active_duty <= req_duty;
    end

endmodule

// File: rtl/prescaled_pwm_gen.sv
// Top of the prescaled PWM channel: registers, prescaler, period
// counter and duty source selection. Single clock, synchronous reset.
module prescaled_pwm_gen
    import ppwm_pkg::*;
#(
    parameter int P_TICKS  = NUM_TICKS,
    parameter int P_DUTY_W = DUTY_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_DATA_W = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_TICKS-1:0]  ref_tick,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic [P_DUTY_W-1:0] pat_duty,
    output logic                pwm_out,
    output logic                period_end
);
    ppwm_cfg_t           cfg;
    logic [P_DUTY_W-1:0] sw_duty;
    logic [P_DUTY_W-1:0] req_duty;
    logic [P_DUTY_W-1:0] cnt;
    logic [P_DUTY_W-1:0] active_duty;
    logic                step;

    ppwm_regs #(
        .P_DUTY_W (P_DUTY_W),
        .P_DATA_W (P_DATA_W),
        .P_ADDR_W (P_ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .sw_duty (sw_duty)
    );

    ppwm_prescaler #(
        .P_TICKS  (P_TICKS),
        .P_TSEL_W (TSEL_W),
        .P_PSEL_W (PSEL_W),
        .P_EXP_W  (EXP_W)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .tick_sel (cfg.tick_sel),
        .pre_sel  (cfg.pre_sel),
        .exp_sel  (cfg.exp_sel),
        .step     (step)
    );

    // Duty source: committed software value or ramp-pattern input
    assign req_duty = cfg.src_sw ? sw_duty : pat_duty;

    ppwm_counter #(
        .P_DUTY_W  (P_DUTY_W),
        .P_SHORT_W (SHORT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .wide        (cfg.wide),
        .glitch_free (cfg.glitch_free),
        .out_en      (cfg.out_en),
        .req_duty    (req_duty),
        .cnt         (cnt),
        .active_duty (active_duty),
        .period_end  (period_end),
        .pwm_out     (pwm_out)
    );

endmodule

// File: rtl/ppwm_chk.sv
// Property checker for the prescaled PWM channel, bound to the top.
module ppwm_chk
    import ppwm_pkg::*;
#(
    parameter int P_DUTY_W = DUTY_W,
    parameter int P_ADDR_W = ADDR_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [P_ADDR_W-1:0] wr_addr,
    input logic                sync_bit,
    input ppwm_cfg_t           cfg,
    input logic [P_DUTY_W-1:0] sw_duty,
    input logic [P_DUTY_W-1:0] active_duty,
    input logic [P_DUTY_W-1:0] cnt,
    input logic                pwm_out,
    input logic                period_end
);
    localparam int FW = P_DUTY_W + 1;

    logic [FW-1:0] full_cnt;
    logic          sync_cmd;

    assign full_cnt = cfg.wide ? FW'(1 << P_DUTY_W) : FW'(1 << SHORT_W);
    assign sync_cmd = wr_en && (wr_addr == A_SYNC) && sync_bit;

    // R9
    out_en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.out_en |-> !pwm_out);

    // R11
    pend_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !period_end);

    // R7
    glitch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.glitch_free && !period_end) |=> $stable(active_duty));

    // R10
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.out_en && ({1'b0, active_duty} >= full_cnt)) |-> pwm_out);

    // R6
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_cmd |=> $stable(sw_duty));

    // R2
    no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.tick_sel == 2'd3) |=> $stable(cnt));

endmodule

bind prescaled_pwm_gen ppwm_chk #(
    .P_DUTY_W (P_DUTY_W),
    .P_ADDR_W (P_ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .sync_bit    (wr_data[0]),
    .cfg         (cfg),
    .sw_duty     (sw_duty),
    .active_duty (active_duty),
    .cnt         (cnt),
    .pwm_out     (pwm_out),
    .period_end  (period_end)
);

// File: tb/prescaled_pwm_gen_test.sv
`timescale 1ns/1ps
// Self-checking bench: measures period length and high time between
// period-end pulses for a vector table, then runs directed cases.
module prescaled_pwm_gen_test;

    localparam int LIMIT = 20000;

    typedef struct packed {
        int tsel;
        int wide;
        int pre;
        int ex;
        int duty;
        int per;
        int hi;
    } vec_t;

    // tick divide: sel0 every clock, sel1 every 2nd, sel2 every 3rd
    localparam vec_t VECS [10] = '{
        '{0, 0, 0, 0,  16,   64,  16},
        '{0, 0, 1, 1,  10,  384,  60},
        '{1, 0, 2, 0,  32,  640, 320},
        '{2, 0, 3, 0,   1, 1152,  18},
        '{0, 0, 0, 3,   0,  512,   0},
        '{0, 0, 0, 0,  64,   64,  64},
        '{0, 0, 0, 0, 300,   64,  64},
        '{0, 1, 0, 0, 200,  512, 200},
        '{0, 1, 0, 0, 511,  512, 511},
        '{0, 0, 0, 7,   5, 8192, 640}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ref_tick = 3'b000;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [8:0] pat_duty = 9'd0;
    logic       pwm_out;
    logic       period_end;

    int errors = 0;
    int checks = 0;
    int tphase = 0;

    prescaled_pwm_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pat_duty   (pat_duty),
        .pwm_out    (pwm_out),
        .period_end (period_end)
    );

    always #2 clk = ~clk;

    // Reference tick generators, updated away from the active edge
    always @(negedge clk) begin
        tphase      <= (tphase == 5) ? 0 : tphase + 1;
        ref_tick[0] <= 1'b1;
        ref_tick[1] <= (tphase % 2 == 0);
        ref_tick[2] <= (tphase % 3 == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Skip to a period end, then count clocks and high clocks of the next period
    task automatic measure(output int per, output int hi);
        int guard = 0;
        per = 0; hi = 0;
        @(negedge clk);
        while (!period_end && guard < LIMIT) begin
            @(negedge clk); guard++;
        end
        do begin
            @(negedge clk); per++;
            if (pwm_out) hi++;
        end while (!period_end && per < LIMIT);
    endtask

    // As measure, but changes pat_duty to new_d after ten clocks of the period
    task automatic measure_switch(input int new_d, output int hi);
        int guard = 0;
        int per = 0;
        hi = 0;
        @(negedge clk);
        while (!period_end && guard < LIMIT) begin
            @(negedge clk); guard++;
        end
        do begin
            @(negedge clk); per++;
            if (pwm_out) hi++;
            if (per == 10) pat_duty = 9'(new_d);
        end while (!period_end && per < LIMIT);
    endtask

    task automatic count_pulses(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (period_end) pulses++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int per, hi, pulses;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: output disabled after reset
        check("R12 pwm_out after reset", int'(pwm_out), 0);
        // R12 R9: default 64-count period, output held low
        measure(per, hi);
        check("R12 default period", per, 64);
        check("R9 R12 high time while disabled", hi, 0);

        // Table: R1 R2 R3 R4 R5 R10 R11 under several settings
        foreach (VECS[k]) begin
            wr(3'd0, 8'(VECS[k].tsel | (VECS[k].wide << 2)));
            wr(3'd1, 8'(VECS[k].pre | (VECS[k].ex << 2)));
            wr(3'd2, 8'(VECS[k].duty & 8'hFF));
            wr(3'd3, 8'(VECS[k].duty >> 8));
            wr(3'd5, 8'h01);
            wr(3'd4, 8'h83);
            measure(per, hi);
            measure(per, hi);
            check($sformatf("R1 R2 R3 R4 R11 period vec%0d", k), per, VECS[k].per);
            check($sformatf("R5 R10 high vec%0d", k), hi, VECS[k].hi);
        end

        // R6: staged duty without sync has no effect
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd3, 8'h00);
        wr(3'd2, 8'd16); wr(3'd5, 8'h01); wr(3'd4, 8'h83);
        measure(per, hi); measure(per, hi);
        check("R6 committed duty", hi, 16);
        wr(3'd2, 8'd40);
        wr(3'd5, 8'h00);
        measure(per, hi); measure(per, hi);
        check("R6 no sync keeps old duty", hi, 16);
        wr(3'd5, 8'h01);
        measure(per, hi); measure(per, hi);
        check("R6 sync applies staged duty", hi, 40);

        // R9: output enable cleared, counter keeps running
        wr(3'd4, 8'h03);
        measure(per, hi);
        check("R9 disabled high time", hi, 0);
        check("R9 period continues", per, 64);

        // R8: pattern source ignores committed software duty
        pat_duty = 9'd20;
        wr(3'd4, 8'h81);
        measure(per, hi); measure(per, hi);
        check("R8 pattern source duty", hi, 20);

        // R7: immediate update mid-period
        pat_duty = 9'd5;
        wr(3'd4, 8'h80);
        measure(per, hi);
        measure_switch(40, hi);
        check("R7 immediate update", hi, 35);
        // R7: glitch-free update waits for period end
        pat_duty = 9'd5;
        wr(3'd4, 8'h81);
        measure(per, hi); measure(per, hi);
        measure_switch(40, hi);
        check("R7 glitch-free holds duty", hi, 5);
        measure(per, hi);
        check("R7 glitch-free applies at boundary", hi, 40);

        // R2: tick select 3 stops the counter
        wr(3'd0, 8'h03);
        count_pulses(300, pulses);
        check("R2 no tick source", pulses, 0);

        // R11: pulse count over a whole number of periods
        wr(3'd0, 8'h00);
        measure(per, hi);
        count_pulses(640, pulses);
        check("R11 pulses in ten periods", pulses, 10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule